// File: doc/BRIEF.md
# Load/Store Alias Protection Unit

This unit lets a code translator move loads above earlier stores and still catch the cases where the reordering was unsafe. A load that was hoisted is issued as a protected load. It writes the byte range it touched into one of a small set of numbered protection slots. The translator picks which slot.

A store that was overtaken by such loads carries a check mask. Each bit of the mask names one slot. The store's byte range is compared only against the valid slots its mask selects. Any intersection raises a sticky alias fault. The surrounding machinery answers that fault with a rollback.

On commit or rollback a clear pulse empties every slot and drops the fault. The translation software and the rollback itself sit outside this block.

Top module: `alias_guard`

## Requirements
- R1: While reset is held and after it is released, `alias_fault` is 0 and every slot is invalid. A store with any mask then raises no fault.
- R2: A cycle with `ld_valid` high and no `clear` writes slot `ld_slot` with `ld_addr` and `ld_size` and marks the slot valid. Loading a slot that is already valid replaces its old range entirely.
- R3: Size codes map to access lengths as follows: 0 is 1 byte, 1 is 2 bytes, and 2 or 3 is 4 bytes. An access covers the bytes from its address up to address plus length minus one, with no wrap past the top of the address space. A store and a slot conflict exactly when their byte ranges share at least one byte.
- R4: Mask bit i selects slot i. A store is compared only against slots whose mask bit is 1 and which are valid. Slots that are unselected or invalid never cause a fault.
- R5: A conflicting store sets `alias_fault` in the cycle after it is presented. The fault then stays 1 through any later traffic until `clear` is applied.
- R6: `clear` drops `alias_fault` and invalidates all slots in the next cycle. It takes priority over a load or a store presented in the same cycle, and both of those are discarded.
- R7: A store presented in the same cycle as a protected load is checked against the slot contents from before that load.
- R8: Several slots may be valid at once. A store whose mask selects several of them faults if it conflicts with any one of them.
- R9: With `st_valid` low, the store inputs are ignored and no fault is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_valid | input | 1 | Protected load present this cycle |
| ld_slot | input | SW = clog2(NUM_SLOTS) | Slot that records the load |
| ld_addr | input | AW | Byte address of the load |
| ld_size | input | 2 | Load size code (0: 1 B, 1: 2 B, 2/3: 4 B) |
| st_valid | input | 1 | Masked store present this cycle |
| st_addr | input | AW | Byte address of the store |
| st_size | input | 2 | Store size code, same encoding as loads |
| st_mask | input | NUM_SLOTS | Slots this store must be checked against |
| clear | input | 1 | Invalidate all slots and drop the fault |
| alias_fault | output | 1 | Sticky conflict indication |

## Verification
The bench builds the unit with its defaults: eight slots and 32-bit addresses. With these values every mask bit and every slot index can be exercised, including slot 7 and masks that select several slots at once. The full address width also brings the top-of-memory case within reach, where a range ending at the highest byte must not wrap onto address zero. Adjacent and one-byte-overlap ranges for each size code probe the intersection test at its edges.

// File: rtl/alias_guard.sv
module alias_guard #(
  parameter int NUM_SLOTS = 8,
  parameter int AW = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ld_valid,
  input  logic [((NUM_SLOTS>1)?$clog2(NUM_SLOTS):1)-1:0] ld_slot,
  input  logic [AW-1:0]        ld_addr,
  input  logic [1:0]           ld_size,
  input  logic                 st_valid,
  input  logic [AW-1:0]        st_addr,
  input  logic [1:0]           st_size,
  input  logic [NUM_SLOTS-1:0] st_mask,
  input  logic                 clear,
  output logic                 alias_fault
);
  localparam int SW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
  localparam int EW = AW + 1;

  function automatic logic [2:0] span_of(input logic [1:0] code);
    case (code)
      2'd0:    span_of = 3'd1;
      2'd1:    span_of = 3'd2;
      default: span_of = 3'd4;
    endcase
  endfunction

  logic [NUM_SLOTS-1:0] slot_vld;
  logic [NUM_SLOTS-1:0] hit;
  logic [EW-1:0]        st_lo, st_hi;
  logic                 take_ld;

  assign take_ld = ld_valid && !clear;
  assign st_lo   = {1'b0, st_addr};
  assign st_hi   = st_lo + {{(EW-3){1'b0}}, span_of(st_size)};

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    logic [AW-1:0] base;
    logic [2:0]    span;
    logic [EW-1:0] lo, hi;

    always_ff @(posedge clk) begin
      if (take_ld && ld_slot == SW'(g)) begin
        base <= ld_addr;
        span <= span_of(ld_size);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slot_vld[g] <= 1'b0;
      else if (clear)
        slot_vld[g] <= 1'b0;
      else if (take_ld && ld_slot == SW'(g))
        slot_vld[g] <= 1'b1;
    end

    assign lo     = {1'b0, base};
    assign hi     = lo + {{(EW-3){1'b0}}, span};
    assign hit[g] = slot_vld[g] && st_mask[g] && (st_lo < hi) && (lo < st_hi);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      alias_fault <= 1'b0;
    else if (clear)
      alias_fault <= 1'b0;
    else if (st_valid && |hit)
      alias_fault <= 1'b1;
  end
endmodule

// File: rtl/alias_guard_chk.sv
module alias_guard_chk #(
  parameter int NUM_SLOTS = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 ld_valid,
  input logic [((NUM_SLOTS>1)?$clog2(NUM_SLOTS):1)-1:0] ld_slot,
  input logic                 st_valid,
  input logic [NUM_SLOTS-1:0] st_mask,
  input logic                 clear,
  input logic                 alias_fault
);
  logic [NUM_SLOTS-1:0] shadow_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      shadow_vld <= '0;
    else if (clear)
      shadow_vld <= '0;
    else if (ld_valid)
      shadow_vld[ld_slot] <= 1'b1;
  end

  a_r1_reset_quiet: assert property (@(posedge clk) !rst_n |-> !alias_fault);

  a_r5_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    alias_fault && !clear |=> alias_fault);

  a_r6_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !alias_fault);

  a_r4_unselected_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !alias_fault && st_valid && ((st_mask & shadow_vld) == '0) |=> !alias_fault);

  a_r9_no_store_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
    !alias_fault && !st_valid |=> !alias_fault);
endmodule

bind alias_guard alias_guard_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_slot(ld_slot),
  .st_valid(st_valid), .st_mask(st_mask), .clear(clear),
  .alias_fault(alias_fault));

// File: tb/tb_alias_guard.sv
module tb_alias_guard;
  localparam int NS = 8;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ld_valid, st_valid, clear;
  logic [2:0]    ld_slot;
  logic [AW-1:0] ld_addr, st_addr;
  logic [1:0]    ld_size, st_size;
  logic [NS-1:0] st_mask;
  logic          alias_fault;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  alias_guard #(.NUM_SLOTS(NS), .AW(AW)) dut (.*);

  // vector: req[3:0] kind[1:0] slot[2:0] addr[31:0] size[1:0] mask[7:0] exp
  // kind 0 load, 1 store, 2 clear
  localparam int NV = 23;
  localparam logic [51:0] VEC [NV] = '{
    {4'd6, 2'd2, 3'd0, 32'h0,   2'd0, 8'h00, 1'b0}, // R6
    {4'd2, 2'd0, 3'd0, 32'h100, 2'd2, 8'h00, 1'b0}, // R2
    {4'd3, 2'd1, 3'd0, 32'h104, 2'd2, 8'h01, 1'b0}, // R3 adjacent
    {4'd4, 2'd1, 3'd0, 32'h103, 2'd0, 8'hFE, 1'b0}, // R4 unselected
    {4'd4, 2'd1, 3'd0, 32'h102, 2'd1, 8'h02, 1'b0}, // R4 invalid slot
    {4'd3, 2'd1, 3'd0, 32'h0FE, 2'd1, 8'h01, 1'b0}, // R3 below
    {4'd3, 2'd1, 3'd0, 32'h0FF, 2'd1, 8'h01, 1'b1}, // R3 one byte overlap
    {4'd5, 2'd1, 3'd0, 32'h500, 2'd0, 8'h00, 1'b1}, // R5 sticky
    {4'd6, 2'd2, 3'd0, 32'h0,   2'd0, 8'h00, 1'b0}, // R6
    {4'd6, 2'd1, 3'd0, 32'h100, 2'd2, 8'h01, 1'b0}, // R6 slots emptied
    {4'd2, 2'd0, 3'd3, 32'h200, 2'd0, 8'h00, 1'b0}, // R2
    {4'd2, 2'd0, 3'd5, 32'h300, 2'd1, 8'h00, 1'b0}, // R2
    {4'd8, 2'd1, 3'd0, 32'h301, 2'd0, 8'h08, 1'b0}, // R8
    {4'd8, 2'd1, 3'd0, 32'h2FE, 2'd2, 8'h28, 1'b1}, // R8 second slot hits
    {4'd6, 2'd2, 3'd0, 32'h0,   2'd0, 8'h00, 1'b0}, // R6
    {4'd2, 2'd0, 3'd3, 32'h200, 2'd3, 8'h00, 1'b0}, // R2
    {4'd2, 2'd0, 3'd3, 32'h400, 2'd0, 8'h00, 1'b0}, // R2 overwrite
    {4'd2, 2'd1, 3'd0, 32'h202, 2'd0, 8'h08, 1'b0}, // R2 old range gone
    {4'd2, 2'd1, 3'd0, 32'h400, 2'd0, 8'h08, 1'b1}, // R2 new range
    {4'd6, 2'd2, 3'd0, 32'h0,   2'd0, 8'h00, 1'b0}, // R6
    {4'd3, 2'd0, 3'd7, 32'h203, 2'd3, 8'h00, 1'b0}, // R3 code 3
    {4'd3, 2'd1, 3'd0, 32'h206, 2'd0, 8'h80, 1'b1}, // R3 code 3 is 4 bytes
    {4'd6, 2'd2, 3'd0, 32'h0,   2'd0, 8'h00, 1'b0}  // R6
  };

  task automatic idle();
    ld_valid = 0; st_valid = 0; clear = 0;
    ld_slot = '0; ld_addr = '0; ld_size = '0;
    st_addr = '0; st_size = '0; st_mask = '0;
  endtask

  task automatic check(input logic got, input logic exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: alias_fault=%0b expected %0b", tag, got, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic do_load(input logic [2:0] s, input logic [31:0] a, input logic [1:0] z);
    @(negedge clk);
    ld_valid = 1; ld_slot = s; ld_addr = a; ld_size = z;
    step();
  endtask

  task automatic do_store(input logic [31:0] a, input logic [1:0] z, input logic [7:0] m);
    @(negedge clk);
    st_valid = 1; st_addr = a; st_size = z; st_mask = m;
    step();
  endtask

  task automatic do_clear();
    @(negedge clk);
    clear = 1;
    step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: alias_fault=%0b expected finish", alias_fault);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    check(alias_fault, 1'b0, "R1 during reset");
    rst_n = 1;
    @(negedge clk);
    check(alias_fault, 1'b0, "R1 after reset");
    do_store(32'h0, 2'd2, 8'hFF);
    check(alias_fault, 1'b0, "R1 slots empty after reset");

    for (int i = 0; i < NV; i++) begin
      logic [51:0] v;
      v = VEC[i];
      @(negedge clk);
      case (v[47:46])
        2'd0: begin ld_valid = 1; ld_slot = v[45:43]; ld_addr = v[42:11]; ld_size = v[10:9]; end
        2'd1: begin st_valid = 1; st_addr = v[42:11]; st_size = v[10:9]; st_mask = v[8:1]; end
        default: clear = 1;
      endcase
      step();
      check(alias_fault, v[0], $sformatf("R%0d vector %0d", v[51:48], i));
    end

    // R7: same-cycle load and store see old slot contents
    @(negedge clk);
    ld_valid = 1; ld_slot = 3'd2; ld_addr = 32'h600; ld_size = 2'd0;
    st_valid = 1; st_addr = 32'h600; st_size = 2'd0; st_mask = 8'h04;
    step();
    check(alias_fault, 1'b0, "R7 same-cycle store uses old slot");
    do_store(32'h600, 2'd0, 8'h04);
    check(alias_fault, 1'b1, "R7 later store sees load");
    do_clear();

    // R6: clear beats a load in the same cycle
    @(negedge clk);
    ld_valid = 1; ld_slot = 3'd1; ld_addr = 32'h700; ld_size = 2'd2; clear = 1;
    step();
    do_store(32'h700, 2'd2, 8'h02);
    check(alias_fault, 1'b0, "R6 load discarded under clear");

    // R6: clear beats a conflicting store in the same cycle
    do_load(3'd1, 32'h700, 2'd2);
    @(negedge clk);
    st_valid = 1; st_addr = 32'h700; st_size = 2'd2; st_mask = 8'h02; clear = 1;
    step();
    check(alias_fault, 1'b0, "R6 store discarded under clear");
    do_store(32'h700, 2'd2, 8'h02);
    check(alias_fault, 1'b0, "R6 slot invalidated by clear");

    // R9: store fields without st_valid
    do_load(3'd4, 32'h800, 2'd2);
    @(negedge clk);
    st_addr = 32'h800; st_size = 2'd2; st_mask = 8'hFF;
    step();
    check(alias_fault, 1'b0, "R9 store ignored without valid");
    do_store(32'h803, 2'd0, 8'h10);
    check(alias_fault, 1'b1, "R9 slot still armed");
    do_clear();
    check(alias_fault, 1'b0, "R6 clear after fault");

    // R3: top of address space does not wrap
    do_load(3'd0, 32'hFFFF_FFFF, 2'd0);
    do_store(32'h0, 2'd2, 8'h01);
    check(alias_fault, 1'b0, "R3 no wrap at top");
    do_store(32'hFFFF_FFFE, 2'd1, 8'h01);
    check(alias_fault, 1'b1, "R3 top byte overlap");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule